// File: doc/BRIEF.md
# Task Reset Mode Controller

This block keeps a per-task start-bank map for a microcoded processor that runs sixteen prioritized microcode tasks. Each task has one mode bit. When the bit is 1 the task begins in the ROM bank, and when it is 0 the task begins in the RAM bank. The starting microaddress of a task always equals its task number, so the map chooses only the bank. A hard reset sets every bit to 1. A load strobe copies the 16-bit processor bus into the map.

A start-function strobe decodes the bus value in one of four ways:
- If the most significant bit is set, the strobe requests a soft reset. The soft reset reuses the stored map, and the block tells the sequencer to hold its next-address update in that cycle.
- If the bus value is between 1 and 3, it is forwarded as a command to the network device.
- Any other nonzero value raises a warning.
- Zero is ignored.

A separate strobe loads a 3-bit register-bank select from the bus. This select is forced to zero when the machine has only the small RAM option.

A small state machine produces the registered outcome of each start strobe. Its states are:
- `ST_IDLE`: no outcome.
- `ST_SOFT`: soft-reset pulse.
- `ST_DEV`: device command strobe.
- `ST_WARN`: warning pulse.

Every accepted start strobe moves the machine to the state that matches its decoded class. Leaving a pulse state without a new strobe returns it to `ST_IDLE`. A soft-reset request that arrives while in `ST_SOFT` goes to `ST_IDLE` instead. This keeps the pulse one cycle wide.

Top module: `rmr_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `mode_bits` is 16'hFFFF and `bank_sel` is 0. `soft_reset`, `dev_cmd_valid`, `dev_cmd_warn` and `strobe_clash` are all 0.
- R2: When `mode_load` is high and `start_strobe` is low, `mode_bits` takes `bus_data` one clock later. At any time, `task_start_rom` equals `mode_bits[task_id]` (1 = ROM bank, 0 = RAM bank) and `task_start_addr` equals `task_id`.
- R3: A start strobe with `bus_data[15]` = 1 makes `soft_reset` high for exactly the one cycle after the strobe edge. `mode_bits` is left unchanged.
- R4: `hold_next` is high, combinationally in the strobe cycle itself, exactly when a soft-reset request is accepted.
- R5: A start strobe with `bus_data[15]` = 0 and `bus_data` in 1..3 gives a one-cycle `dev_cmd_valid` in the next cycle, with `dev_cmd` = `bus_data[1:0]`.
- R6: A start strobe with `bus_data[15]` = 0 and `bus_data` of 4 or more gives a one-cycle `dev_cmd_warn` and no device command. At most one of `soft_reset`, `dev_cmd_valid` and `dev_cmd_warn` is high in any cycle.
- R7: A start strobe with `bus_data` = 0 produces no pulse on any output.
- R8: `bank_load` sets `bank_sel` to `bus_data[3:1]` one clock later, or to 0 when `small_ram` is 1.
- R9: When `mode_load` and `start_strobe` are both high, the load takes effect and the start strobe is ignored (no `hold_next`, no pulse). `strobe_clash` is then high for one cycle.
- R10: A soft-reset request that arrives in the cycle where `soft_reset` is high is dropped. It raises no `hold_next` and no second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_data | input | 16 | Processor bus |
| mode_load | input | 1 | Load the mode map from the bus |
| start_strobe | input | 1 | Start-function strobe |
| bank_load | input | 1 | Load the register-bank select from the bus |
| small_ram | input | 1 | Small-RAM configuration; forces the bank select to 0 |
| task_id | input | 4 | Task whose start point is queried |
| mode_bits | output | 16 | Current mode map, one bit per task |
| task_start_addr | output | 4 | Start microaddress of the queried task |
| task_start_rom | output | 1 | 1 if the queried task starts in ROM |
| soft_reset | output | 1 | Registered one-cycle soft-reset pulse |
| hold_next | output | 1 | Suppress the next-address update in this cycle |
| dev_cmd_valid | output | 1 | Device command strobe |
| dev_cmd | output | 2 | Device command code |
| dev_cmd_warn | output | 1 | Unsupported start code pulse |
| bank_sel | output | 3 | Register-bank select |
| strobe_clash | output | 1 | Load and start strobes collided |

## Verification
The bench sweeps every start code from 0 to 15, together with top-of-range and soft-reset values. This catches a wrong range boundary: a design that gets it wrong forwards code 4 as a device command, or warns on code 3. It reads back every task's bank for several map patterns, so a reversed bit order would show up as wrong banks for the high-priority tasks. It drives back-to-back soft-reset requests, which a design without the drop rule would answer with a two-cycle pulse. It also drives colliding strobes, which a design with the wrong priority would answer with a soft reset and a stale map. Every bank-select input is tried with both configurations, which catches a misplaced field or a missing small-RAM override.

// File: rtl/rmr_pkg.sv
package rmr_pkg;

    // Outcome class of a start-function strobe.
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_SOFT = 2'd1,
        CLS_DEV  = 2'd2,
        CLS_WARN = 2'd3
    } start_cls_t;

    // Registered outcome state of the start sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOFT = 2'd1,
        ST_DEV  = 2'd2,
        ST_WARN = 2'd3
    } seq_state_t;

endpackage

// File: rtl/rmr_start_decode.sv
module rmr_start_decode
    import rmr_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int CMD_LIMIT = 4,
    localparam int CMD_W    = $clog2(CMD_LIMIT)
) (
    input  logic [BUS_W-1:0] bus_in,
    output start_cls_t       cls,
    output logic [CMD_W-1:0] cmd
);

    localparam logic [BUS_W-1:0] LIMIT_V = BUS_W'(CMD_LIMIT);

    always_comb begin
        cmd = bus_in[CMD_W-1:0];
        if (bus_in[BUS_W-1]) begin
            cls = CLS_SOFT;
        end else if (bus_in == '0) begin
            cls = CLS_NONE;
        end else if (bus_in < LIMIT_V) begin
            cls = CLS_DEV;
        end else begin
            cls = CLS_WARN;
        end
    end

endmodule

// File: rtl/rmr_mode_reg.sv
module rmr_mode_reg #(
    parameter int NUM_TASKS = 16,
    localparam int TID_W    = $clog2(NUM_TASKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_TASKS-1:0] data_in,
    input  logic [TID_W-1:0]     task_id,
    output logic [NUM_TASKS-1:0] mode_q,
    output logic [TID_W-1:0]     start_addr,
    output logic                 start_rom
);

    // One flop per task; hard reset selects the ROM bank for all.
    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q[t] <= 1'b1;
            end else if (load) begin
                mode_q[t] <= data_in[t];
            end
        end
    end

    // Task i always starts at microaddress i; the map picks only the bank.
    always_comb begin
        start_addr = task_id;
        start_rom  = mode_q[task_id];
    end

endmodule

// File: rtl/rmr_bank_sel.sv
module rmr_bank_sel #(
    parameter int BUS_W  = 16,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              small_ram,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BANK_W-1:0] bank_q
);

    logic [BANK_W-1:0] bank_d;

    always_comb begin
        bank_d = small_ram ? '0 : bus_in[BANK_W:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/rmr_seq.sv
module rmr_seq
    import rmr_pkg::*;
#(
    parameter int CMD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  start_cls_t       cls,
    input  logic [CMD_W-1:0] cmd_in,
    output logic             soft_reset,
    output logic             hold_next,
    output logic             dev_valid,
    output logic [CMD_W-1:0] dev_cmd,
    output logic             warn
);

    seq_state_t state_q, state_d;
    logic       accept_soft;

    // Next-state logic.
    always_comb begin
        accept_soft = 1'b0;
        state_d     = ST_IDLE;
        if (go) begin
            unique case (cls)
                CLS_NONE: state_d = ST_IDLE;
                CLS_SOFT: begin
                    if (state_q != ST_SOFT) begin
                        state_d     = ST_SOFT;
                        accept_soft = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                CLS_DEV:  state_d = ST_DEV;
                CLS_WARN: state_d = ST_WARN;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_cmd <= '0;
        end else if (go && cls == CLS_DEV) begin
            dev_cmd <= cmd_in;
        end
    end

    // Outputs.
    always_comb begin
        soft_reset = 1'b0;
        dev_valid  = 1'b0;
        warn       = 1'b0;
        hold_next  = accept_soft;
        unique case (state_q)
            ST_IDLE: ;
            ST_SOFT: soft_reset = 1'b1;
            ST_DEV:  dev_valid  = 1'b1;
            ST_WARN: warn       = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rmr_ctrl.sv
module rmr_ctrl
    import rmr_pkg::*;
#(
    parameter int NUM_TASKS = 16,
    parameter int BANK_W    = 3,
    parameter int CMD_LIMIT = 4,
    localparam int BUS_W    = NUM_TASKS,
    localparam int TID_W    = $clog2(NUM_TASKS),
    localparam int CMD_W    = $clog2(CMD_LIMIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              mode_load,
    input  logic              start_strobe,
    input  logic              bank_load,
    input  logic              small_ram,
    input  logic [TID_W-1:0]  task_id,
    output logic [BUS_W-1:0]  mode_bits,
    output logic [TID_W-1:0]  task_start_addr,
    output logic              task_start_rom,
    output logic              soft_reset,
    output logic              hold_next,
    output logic              dev_cmd_valid,
    output logic [CMD_W-1:0]  dev_cmd,
    output logic              dev_cmd_warn,
    output logic [BANK_W-1:0] bank_sel,
    output logic              strobe_clash
);

    start_cls_t       cls;
    logic [CMD_W-1:0] cmd;
    logic             start_go;

    // Load has priority over a simultaneous start strobe.
    assign start_go = start_strobe && !mode_load;

    rmr_mode_reg #(.NUM_TASKS(NUM_TASKS)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (mode_load),
        .data_in    (bus_data),
        .task_id    (task_id),
        .mode_q     (mode_bits),
        .start_addr (task_start_addr),
        .start_rom  (task_start_rom)
    );

    rmr_start_decode #(.BUS_W(BUS_W), .CMD_LIMIT(CMD_LIMIT)) u_dec (
        .bus_in (bus_data),
        .cls    (cls),
        .cmd    (cmd)
    );

    rmr_seq #(.CMD_W(CMD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (start_go),
        .cls        (cls),
        .cmd_in     (cmd),
        .soft_reset (soft_reset),
        .hold_next  (hold_next),
        .dev_valid  (dev_cmd_valid),
        .dev_cmd    (dev_cmd),
        .warn       (dev_cmd_warn)
    );

    rmr_bank_sel #(.BUS_W(BUS_W), .BANK_W(BANK_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (bank_load),
        .small_ram (small_ram),
        .bus_in    (bus_data),
        .bank_q    (bank_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_clash <= 1'b0;
        end else begin
            strobe_clash <= mode_load && start_strobe;
        end
    end

endmodule

// File: rtl/rmr_ctrl_chk.sv
module rmr_ctrl_chk #(
    parameter int BUS_W  = 16,
    parameter int BANK_W = 3,
    parameter int CMD_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_load,
    input logic              start_strobe,
    input logic              bank_load,
    input logic              small_ram,
    input logic [BUS_W-1:0]  mode_bits,
    input logic              soft_reset,
    input logic              hold_next,
    input logic              dev_cmd_valid,
    input logic [CMD_W-1:0]  dev_cmd,
    input logic              dev_cmd_warn,
    input logic [BANK_W-1:0] bank_sel,
    input logic              strobe_clash
);

    // R3
    a_r3_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> !soft_reset);

    // R4
    a_r4_hold_leads_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hold_next |=> soft_reset);

    // R2
    a_r2_map_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_load) |-> $stable(mode_bits));

    // R5
    a_r5_cmd_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        dev_cmd_valid |-> dev_cmd != '0);

    // R6
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({soft_reset, dev_cmd_valid, dev_cmd_warn}));

    // R8
    a_r8_small_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_load && small_ram) |=> bank_sel == '0);

    // R9
    a_r9_clash_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && start_strobe) |=> strobe_clash);

    // R9
    a_r9_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && start_strobe) |-> !hold_next);

    // R10
    a_r10_no_rehold: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> !hold_next);

endmodule

bind rmr_ctrl rmr_ctrl_chk #(.BUS_W(BUS_W), .BANK_W(BANK_W), .CMD_W(CMD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_load     (mode_load),
    .start_strobe  (start_strobe),
    .bank_load     (bank_load),
    .small_ram     (small_ram),
    .mode_bits     (mode_bits),
    .soft_reset    (soft_reset),
    .hold_next     (hold_next),
    .dev_cmd_valid (dev_cmd_valid),
    .dev_cmd       (dev_cmd),
    .dev_cmd_warn  (dev_cmd_warn),
    .bank_sel      (bank_sel),
    .strobe_clash  (strobe_clash)
);

// File: tb/sim_rmr_ctrl.sv
`timescale 1ns/1ps
module sim_rmr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_data = '0;
    logic        mode_load = 1'b0;
    logic        start_strobe = 1'b0;
    logic        bank_load = 1'b0;
    logic        small_ram = 1'b0;
    logic [3:0]  task_id = '0;
    logic [15:0] mode_bits;
    logic [3:0]  task_start_addr;
    logic        task_start_rom;
    logic        soft_reset, hold_next, dev_cmd_valid, dev_cmd_warn, strobe_clash;
    logic [1:0]  dev_cmd;
    logic [2:0]  bank_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rmr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .mode_load(mode_load),
        .start_strobe(start_strobe), .bank_load(bank_load), .small_ram(small_ram),
        .task_id(task_id), .mode_bits(mode_bits), .task_start_addr(task_start_addr),
        .task_start_rom(task_start_rom), .soft_reset(soft_reset), .hold_next(hold_next),
        .dev_cmd_valid(dev_cmd_valid), .dev_cmd(dev_cmd), .dev_cmd_warn(dev_cmd_warn),
        .bank_sel(bank_sel), .strobe_clash(strobe_clash)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic quiet(input string req);
        chk(!soft_reset && !dev_cmd_valid && !dev_cmd_warn && !strobe_clash, req,
            {soft_reset, dev_cmd_valid, dev_cmd_warn, strobe_clash}, 0);
    endtask

    task automatic sweep_tasks(input logic [15:0] pat, input string req);
        for (int t = 0; t < 16; t++) begin
            task_id = 4'(t);
            #0.1;
            chk(task_start_rom == pat[t], req, task_start_rom, pat[t]);
            chk(task_start_addr == 4'(t), req, task_start_addr, t);
        end
    endtask

    task automatic load_map(input logic [15:0] pat);
        @(negedge clk);
        bus_data = pat; mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0; bus_data = '0;
    endtask

    // Drive one start strobe; sample hold_next in the strobe cycle, pulses one cycle later.
    task automatic start_cmd(input logic [15:0] v, output bit hold_seen);
        @(negedge clk);
        bus_data = v; start_strobe = 1'b1;
        #0.5 hold_seen = hold_next;
        @(negedge clk);
        start_strobe = 1'b0; bus_data = '0;
    endtask

    initial begin
        bit h;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(mode_bits == 16'hFFFF, "R1", mode_bits, 16'hFFFF);
        chk(bank_sel == 3'd0, "R1", bank_sel, 0);
        quiet("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_bits == 16'hFFFF, "R1", mode_bits, 16'hFFFF);
        quiet("R1");
        sweep_tasks(16'hFFFF, "R1");

        // R2: several map patterns, all tasks read back
        begin
            logic [15:0] pats [5] = '{16'hA5C3, 16'h0000, 16'h8001, 16'h7FFE, 16'h1234};
            foreach (pats[i]) begin
                load_map(pats[i]);
                chk(mode_bits == pats[i], "R2", mode_bits, pats[i]);
                sweep_tasks(pats[i], "R2");
            end
        end
        for (int k = 0; k < 16; k++) begin
            load_map(16'(1) << k);
            sweep_tasks(16'(1) << k, "R2");
        end

        // R5 R6 R7: sweep start codes with MSB clear
        for (int v = 0; v < 18; v++) begin
            logic [15:0] val;
            bit exp_dev, exp_warn;
            val = (v == 16) ? 16'h7FFF : (v == 17) ? 16'h0004 : 16'(v);
            exp_dev  = (val != 0) && (val < 4);
            exp_warn = (val >= 4);
            start_cmd(val, h);
            chk(h == 1'b0, "R4", h, 0);
            chk(dev_cmd_valid == exp_dev, exp_dev ? "R5" : (exp_warn ? "R6" : "R7"),
                dev_cmd_valid, exp_dev);
            chk(dev_cmd_warn == exp_warn, exp_warn ? "R6" : "R7", dev_cmd_warn, exp_warn);
            chk(soft_reset == 1'b0, "R7", soft_reset, 0);
            if (exp_dev) chk(dev_cmd == val[1:0], "R5", dev_cmd, val[1:0]);
            @(negedge clk);
            quiet("R5");
        end

        // R3 R4: soft reset reuses the stored map
        load_map(16'h1234);
        start_cmd(16'h8000, h);
        chk(h == 1'b1, "R4", h, 1);
        chk(soft_reset == 1'b1, "R3", soft_reset, 1);
        chk(mode_bits == 16'h1234, "R3", mode_bits, 16'h1234);
        @(negedge clk);
        chk(soft_reset == 1'b0, "R3", soft_reset, 0);
        start_cmd(16'hFFFF, h);
        chk(h == 1'b1 && soft_reset == 1'b1, "R3", {h, soft_reset}, 3);
        chk(dev_cmd_warn == 1'b0, "R3", dev_cmd_warn, 0);
        @(negedge clk);
        quiet("R3");

        // R10: request during the pulse is dropped
        @(negedge clk);
        bus_data = 16'h8000; start_strobe = 1'b1;
        @(negedge clk);
        chk(soft_reset == 1'b1, "R10", soft_reset, 1);
        #0.5 chk(hold_next == 1'b0, "R10", hold_next, 0);
        @(negedge clk);
        start_strobe = 1'b0; bus_data = '0;
        chk(soft_reset == 1'b0, "R10", soft_reset, 0);
        @(negedge clk);
        quiet("R10");

        // R8: bank select over all low-nibble values and both configurations
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 16; b++) begin
                logic [2:0] eb;
                eb = (s == 1) ? 3'd0 : 3'((b >> 1) & 7);
                @(negedge clk);
                small_ram = s[0]; bus_data = 16'(b) | 16'h0F00; bank_load = 1'b1;
                @(negedge clk);
                bank_load = 1'b0; bus_data = '0;
                chk(bank_sel == eb, "R8", bank_sel, eb);
            end
        end
        small_ram = 1'b0;
        load_map(16'hFFFF);
        chk(bank_sel == 3'd0, "R8", bank_sel, 0);

        // R9: collision, load wins
        @(negedge clk);
        bus_data = 16'h8001; mode_load = 1'b1; start_strobe = 1'b1;
        #0.5 chk(hold_next == 1'b0, "R9", hold_next, 0);
        @(negedge clk);
        mode_load = 1'b0; start_strobe = 1'b0; bus_data = '0;
        chk(strobe_clash == 1'b1, "R9", strobe_clash, 1);
        chk(soft_reset == 1'b0, "R9", soft_reset, 0);
        chk(mode_bits == 16'h8001, "R9", mode_bits, 16'h8001);
        @(negedge clk);
        chk(strobe_clash == 1'b0, "R9", strobe_clash, 0);
        @(negedge clk);
        bus_data = 16'h0002; mode_load = 1'b1; start_strobe = 1'b1;
        @(negedge clk);
        mode_load = 1'b0; start_strobe = 1'b0; bus_data = '0;
        chk(dev_cmd_valid == 1'b0, "R9", dev_cmd_valid, 0);
        chk(mode_bits == 16'h0002, "R9", mode_bits, 16'h0002);
        @(negedge clk);
        quiet("R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule